// File: doc/BRIEF.md
# Serial Converter Read Sequencer

This block sits on the host side of a 16-bit serial analog-to-digital converter that reports its state on a BUSY line and can mark the start of a result frame with a SYNC bit. On a start request it asserts the read/convert select low for one data-clock period to begin a conversion. It then waits for BUSY to fall and sends a gated burst of data clocks, divided down from the system clock, while it shifts in the serial data bit. The assembled word is delivered with a one-cycle strobe.

Two read modes are selected per transaction. The overlapped mode reads the previous conversion's result while the new conversion runs, and ends early enough to leave the second half of the BUSY-low interval quiet. The post-conversion mode waits for BUSY to return high. It sends an arming pulse with chip select deasserted, checks the SYNC bit that the converter returns, and then reads the fresh result. A second input selects whether bits are captured on rising or falling data-clock edges. Together the mode and the edge set the burst length and the pulse at which each bit is taken.

Top module: `adc_read_seq`

## Requirements
- R1: After reset, adcCsN is 0, adcRdConvN is 1, adcDclk is 0, wordValid and frameErr are 0, and wordOut is 0.
- R2: A startReq seen while idle drives adcRdConvN low for exactly 2*DIV_HALF system cycles, with adcDclk low throughout. A startReq seen while a transaction is in progress starts no further conversion.
- R3: Within a burst, every high and every low phase of adcDclk lasts exactly DIV_HALF system cycles. adcDclk rests low between bursts.
- R4: Overlapped mode (modeAfter=0) starts its burst only after BUSY is seen low. It sends 16 pulses when edgeRise=0 and 17 when edgeRise=1. The last falling edge comes no later than 4 + 2*DIV_HALF*pulses system cycles after BUSY falls.
- R5: In overlapped mode, with pulses numbered from 1, bit 15 is taken on falling edge 1 (edgeRise=0) or rising edge 2 (edgeRise=1). Each later bit is taken one pulse later, down to bit 0. The word equals the result of the conversion before the one just started.
- R6: Post-conversion mode (modeAfter=1) sends no pulse while BUSY is low. After BUSY rises it sends 18 pulses (edgeRise=0) or 19 (edgeRise=1), numbered from 0. adcCsN is high across the rising edge of pulse 0 and low at every other rising edge.
- R7: In post-conversion mode, bit 15 is taken on falling edge 2 or rising edge 3, and bit 0 on falling edge 17 or rising edge 18. The word equals the result of the conversion just started.
- R8: In post-conversion mode, SYNC is sampled on falling edge 1 (edgeRise=0) or rising edge 2 (edgeRise=1). If it is low, frameErr pulses for one cycle at the end of the burst and wordValid stays low.
- R9: wordValid is a single-cycle pulse, once per good transaction. wordOut changes only together with it and otherwise holds its last value.
- R10: modeAfter and edgeRise are latched when the start is accepted. Changing them during a transaction does not alter its burst or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request one conversion and read |
| modeAfter | input | 1 | 0: read previous result during conversion; 1: read current result after BUSY rises |
| edgeRise | input | 1 | 0: capture on falling data-clock edges; 1: on rising edges |
| adcBusy | input | 1 | Converter BUSY, low while converting |
| adcSync | input | 1 | Converter frame-start bit |
| adcData | input | 1 | Converter serial data |
| adcCsN | output | 1 | Chip select, active low |
| adcRdConvN | output | 1 | Read/convert select, low starts a conversion |
| adcDclk | output | 1 | Gated data clock |
| wordOut | output | DATA_W | Last accepted word |
| wordValid | output | 1 | One-cycle strobe for a new word |
| frameErr | output | 1 | One-cycle strobe for a missing SYNC |

## Verification
A fresh start request can arrive while a burst is clocking. A change of modeAfter and edgeRise can also land in the middle of that same burst. The bench provokes this in two transactions by pulsing startReq again and flipping both configuration inputs a few cycles after the accepted start. It then judges the outcome by counting conversion pulses on adcRdConvN and data-clock rising edges, and by comparing the delivered word against the result expected for the latched settings.

// File: rtl/adc_read_pkg.sv
package adc_read_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CONV,
    S_WAIT_LO,
    S_WAIT_HI,
    S_PREP,
    S_BURST
  } seqState_t;

  // strobes from the sequencer to the capture datapath
  typedef struct packed {
    logic clear;
    logic shift;
    logic syncChk;
    logic finish;
    logic postMode;
  } dpStrobe_t;

endpackage

// File: rtl/adc_read_clkgen.sv
module adc_read_clkgen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  output logic halfTick
);

  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!en || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign halfTick = en && (cnt == LAST);

endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
  import adc_read_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      modeAfter,
  input  logic      edgeRise,
  input  logic      adcBusy,
  input  logic      halfTick,
  output logic      tickEn,
  output logic      csN,
  output logic      rdConvN,
  output logic      dclk,
  output dpStrobe_t dp
);

  localparam int MAXP = DATA_W + 3;
  localparam int HW   = $clog2(2 * MAXP + 1);

  seqState_t st;
  logic [SYNC_STAGES-1:0] busyPipe;
  logic busyS;
  logic cfgPost, cfgRise;
  logic [HW-1:0] halfCnt;
  logic convTick;
  logic csNQ, rdcQ, dclkQ;

  logic [HW-1:0] firstCap, lastCap, numPulses, lastHalf, nextHalf, pulseNum;
  logic isRiseNext, edgeMatch, burstTick, burstEnd;

  assign busyS = busyPipe[SYNC_STAGES-1];

  always_comb begin
    firstCap   = HW'(1) + (cfgPost ? HW'(1) : HW'(0)) + (cfgRise ? HW'(1) : HW'(0));
    lastCap    = firstCap + HW'(DATA_W - 1);
    numPulses  = lastCap + (cfgPost ? HW'(1) : HW'(0));
    lastHalf   = (numPulses << 1) - HW'(1);
    nextHalf   = halfCnt + HW'(1);
    pulseNum   = (nextHalf >> 1) + (cfgPost ? HW'(0) : HW'(1));
    isRiseNext = ~nextHalf[0];
    edgeMatch  = (isRiseNext == cfgRise);
    burstTick  = (st == S_BURST) && halfTick && (halfCnt != lastHalf);
    burstEnd   = (st == S_BURST) && halfTick && (halfCnt == lastHalf);

    dp.clear    = (st == S_IDLE) && startReq;
    dp.shift    = burstTick && edgeMatch && (pulseNum >= firstCap) && (pulseNum <= lastCap);
    dp.syncChk  = burstTick && edgeMatch && cfgPost && (pulseNum == firstCap - HW'(1));
    dp.finish   = burstEnd;
    dp.postMode = cfgPost;
  end

  assign tickEn  = (st == S_CONV) || (st == S_PREP) || (st == S_BURST);
  assign csN     = csNQ;
  assign rdConvN = rdcQ;
  assign dclk    = dclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= S_IDLE;
      busyPipe <= '1;
      cfgPost  <= 1'b0;
      cfgRise  <= 1'b0;
      halfCnt  <= '0;
      convTick <= 1'b0;
      csNQ     <= 1'b0;
      rdcQ     <= 1'b1;
      dclkQ    <= 1'b0;
    end else begin
      busyPipe <= {busyPipe[SYNC_STAGES-2:0], adcBusy};
      unique case (st)
        S_IDLE: begin
          if (startReq) begin
            cfgPost  <= modeAfter;
            cfgRise  <= edgeRise;
            rdcQ     <= 1'b0;
            convTick <= 1'b0;
            st       <= S_CONV;
          end
        end
        S_CONV: begin
          if (halfTick) begin
            if (convTick) begin
              rdcQ <= 1'b1;
              st   <= S_WAIT_LO;
            end else begin
              convTick <= 1'b1;
            end
          end
        end
        S_WAIT_LO: begin
          if (!busyS) begin
            if (cfgPost) begin
              st <= S_WAIT_HI;
            end else begin
              dclkQ   <= 1'b1;
              halfCnt <= '0;
              st      <= S_BURST;
            end
          end
        end
        S_WAIT_HI: begin
          if (busyS) begin
            if (cfgPost) begin
              csNQ <= 1'b1;
              st   <= S_PREP;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_PREP: begin
          if (halfTick) begin
            dclkQ   <= 1'b1;
            halfCnt <= '0;
            st      <= S_BURST;
          end
        end
        S_BURST: begin
          if (halfTick) begin
            if (halfCnt == lastHalf) begin
              st <= cfgPost ? S_IDLE : S_WAIT_HI;
            end else begin
              halfCnt <= nextHalf;
              dclkQ   <= ~dclkQ;
              if (cfgPost && halfCnt == '0) csNQ <= 1'b0;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  conv_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdcQ |-> !dclkQ);

  // R6
  arm_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    csNQ |-> (rdcQ && (st == S_PREP || st == S_BURST)));

  // R3
  dclk_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_BURST && $past(st) == S_BURST && !$stable(dclkQ)) |-> $past(halfTick));

endmodule

// File: rtl/adc_read_dpath.sv
module adc_read_dpath
  import adc_read_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         dp,
  input  logic              adcData,
  input  logic              adcSync,
  output logic [DATA_W-1:0] wordOut,
  output logic              wordValid,
  output logic              frameErr
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              syncBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitCnt    <= '0;
      syncBad   <= 1'b0;
      wordOut   <= '0;
      wordValid <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      frameErr  <= 1'b0;
      if (dp.clear) begin
        shiftReg <= '0;
        bitCnt   <= '0;
        syncBad  <= 1'b0;
      end else begin
        if (dp.shift) begin
          shiftReg <= {shiftReg[DATA_W-2:0], adcData};
          bitCnt   <= bitCnt + CNT_W'(1);
        end
        if (dp.syncChk) syncBad <= ~adcSync;
        if (dp.finish) begin
          if (dp.postMode && syncBad) begin
            frameErr <= 1'b1;
          end else begin
            wordValid <= 1'b1;
            wordOut   <= shiftReg;
          end
        end
      end
    end
  end

  // R5 R7
  bit_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    dp.finish |-> (bitCnt == CNT_W'(DATA_W)));

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wordValid && frameErr));

endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
  import adc_read_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DIV_HALF    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              modeAfter,
  input  logic              edgeRise,
  input  logic              adcBusy,
  input  logic              adcSync,
  input  logic              adcData,
  output logic              adcCsN,
  output logic              adcRdConvN,
  output logic              adcDclk,
  output logic [DATA_W-1:0] wordOut,
  output logic              wordValid,
  output logic              frameErr
);

  logic      tickEn;
  logic      halfTick;
  dpStrobe_t dpStb;

  adc_read_clkgen #(.DIV_HALF(DIV_HALF)) u_clkgen (
    .clk      (clk),
    .rstN     (rstN),
    .en       (tickEn),
    .halfTick (halfTick)
  );

  adc_read_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .modeAfter (modeAfter),
    .edgeRise  (edgeRise),
    .adcBusy   (adcBusy),
    .halfTick  (halfTick),
    .tickEn    (tickEn),
    .csN       (adcCsN),
    .rdConvN   (adcRdConvN),
    .dclk      (adcDclk),
    .dp        (dpStb)
  );

  adc_read_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .dp        (dpStb),
    .adcData   (adcData),
    .adcSync   (adcSync),
    .wordOut   (wordOut),
    .wordValid (wordValid),
    .frameErr  (frameErr)
  );

endmodule

// File: tb/adc_read_seq_test.sv
module adc_read_seq_test;

  localparam int DIV_HALF = 2;
  localparam int BUSY_DLY = 3;
  localparam int BUSY_LOW = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic modeAfter = 1'b0;
  logic edgeRise = 1'b0;
  logic adcBusy = 1'b1;
  logic adcSync = 1'b0;
  logic adcData = 1'b0;
  logic adcCsN, adcRdConvN, adcDclk, wordValid, frameErr;
  logic [15:0] wordOut;

  adc_read_seq #(.DATA_W(16), .DIV_HALF(DIV_HALF), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .modeAfter(modeAfter),
    .edgeRise(edgeRise), .adcBusy(adcBusy), .adcSync(adcSync), .adcData(adcData),
    .adcCsN(adcCsN), .adcRdConvN(adcRdConvN), .adcDclk(adcDclk),
    .wordOut(wordOut), .wordValid(wordValid), .frameErr(frameErr)
  );

  always #10 clk = ~clk;

  int passCnt = 0;
  int failCnt = 0;

  // converter model state
  logic [15:0] nextWord = 16'h0000, curWord = 16'h0000, prevWord = 16'h0000;
  logic killSync = 1'b0;
  logic armed = 1'b0;
  int rc = 0, busyDly = 0, busyLeft = 0;

  // monitor state
  int txnId = 0, seenTxn = 0;
  logic prevD = 1'b0, prevRc = 1'b1, prevValid = 1'b0;
  logic [15:0] prevWordOut = 16'h0000, gotWord = 16'h0000;
  int riseCnt = 0, riseCsHigh = 0, riseBusyLow = 0, convCnt = 0, convLen = 0, convLenLast = 0;
  int runLen = 0, halfMin = 0, halfMax = 0, busyLowAge = 0, lastFallAge = 0;
  int validCnt = 0, errCnt = 0;
  logic edgeSeen = 1'b0, validWide = 1'b0, wordMoved = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (txnId != seenTxn) begin
        seenTxn = txnId;
        riseCnt = 0; riseCsHigh = 0; riseBusyLow = 0; convCnt = 0; convLenLast = 0;
        runLen = 0; halfMin = 1000000; halfMax = 0; lastFallAge = 0;
        validCnt = 0; errCnt = 0; edgeSeen = 0; validWide = 0; wordMoved = 0;
      end
      // observation
      if (!adcBusy) busyLowAge++;
      if (adcDclk != prevD) begin
        if (edgeSeen) begin
          if (runLen < halfMin) halfMin = runLen;
          if (runLen > halfMax) halfMax = runLen;
        end
        edgeSeen = 1'b1;
        runLen = 1;
      end else begin
        runLen++;
      end
      if (adcDclk && !prevD) begin
        riseCnt++;
        if (adcCsN) riseCsHigh++;
        if (!adcBusy) riseBusyLow++;
      end
      if (!adcDclk && prevD && !adcBusy) lastFallAge = busyLowAge;
      if (!adcRdConvN) begin
        if (prevRc) begin
          convCnt++;
          convLen = 0;
          prevWord = curWord;
          curWord = nextWord;
          rc = 0;
          armed = 1'b0;
          busyDly = BUSY_DLY;
        end
        convLen++;
      end else if (!prevRc) begin
        convLenLast = convLen;
      end
      if (wordValid) begin
        validCnt++;
        gotWord = wordOut;
        if (prevValid) validWide = 1'b1;
      end else if (wordOut != prevWordOut) begin
        wordMoved = 1'b1;
      end
      if (frameErr) errCnt++;
      // converter behaviour
      if (busyDly > 0) begin
        busyDly--;
        if (busyDly == 0) begin
          adcBusy = 1'b0;
          busyLeft = BUSY_LOW;
          busyLowAge = 0;
        end
      end else if (busyLeft > 0) begin
        busyLeft--;
        if (busyLeft == 0) adcBusy = 1'b1;
      end
      if (adcDclk && !prevD) begin
        if (adcCsN) begin
          armed = 1'b1;
          rc = 0;
        end else begin
          rc++;
        end
        adcSync = 1'b0;
        adcData = 1'b0;
        if (armed) begin
          if (rc == 1) adcSync = !killSync;
          else if (rc >= 2 && rc <= 17) adcData = curWord[17-rc];
        end else if (rc >= 1 && rc <= 16) begin
          adcData = prevWord[16-rc];
        end
      end
    end
    prevD = adcDclk;
    prevRc = adcRdConvN;
    prevValid = wordValid;
    prevWordOut = wordOut;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic txn(input logic post, input logic rise, input logic [15:0] word,
                     input logic kill, input logic [15:0] expWord, input logic expErr,
                     input logic disturb);
    int pulses;
    @(negedge clk);
    modeAfter = post; edgeRise = rise; nextWord = word; killSync = kill;
    txnId++;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (disturb) begin
      repeat (6) @(negedge clk);
      modeAfter = !post; edgeRise = !rise; startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
    end
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      if ((validCnt + errCnt) > 0 && adcBusy && busyDly == 0) break;
    end
    repeat (10) @(negedge clk);
    #1;
    pulses = post ? (rise ? 19 : 18) : (rise ? 17 : 16);
    if (expErr) begin
      chk(errCnt == 1, "R8 frameErr count", errCnt, 1);
      chk(validCnt == 0, "R8 no wordValid on bad SYNC", validCnt, 0);
      chk(wordOut == expWord, "R9 wordOut held", wordOut, expWord);
    end else begin
      chk(validCnt == 1, "R9 wordValid count", validCnt, 1);
      chk(!validWide, "R9 wordValid width", validWide, 0);
      chk(gotWord == expWord, post ? "R7 post word" : "R5 overlapped word", gotWord, expWord);
      chk(errCnt == 0, "R8 no frameErr", errCnt, 0);
    end
    chk(!wordMoved, "R9 wordOut moved without strobe", wordMoved, 0);
    chk(riseCnt == pulses, post ? "R6 pulse count" : "R4 pulse count", riseCnt, pulses);
    if (disturb) chk(riseCnt == pulses, "R10 latched config pulse count", riseCnt, pulses);
    chk(convCnt == 1, "R2 one conversion per transaction", convCnt, 1);
    chk(convLenLast == 2 * DIV_HALF, "R2 convert pulse length", convLenLast, 2 * DIV_HALF);
    chk(halfMin == DIV_HALF, "R3 shortest half period", halfMin, DIV_HALF);
    chk(halfMax == DIV_HALF, "R3 longest half period", halfMax, DIV_HALF);
    chk(adcDclk == 1'b0, "R3 data clock idles low", adcDclk, 0);
    if (post) begin
      chk(riseCsHigh == 1, "R6 arming edge with select high", riseCsHigh, 1);
      chk(riseBusyLow == 0, "R6 no pulse while BUSY low", riseBusyLow, 0);
    end else begin
      chk(riseCsHigh == 0, "R6 no arming edge in overlapped mode", riseCsHigh, 0);
      chk(lastFallAge <= 4 + 2 * DIV_HALF * pulses, "R4 burst ends early in BUSY low",
          lastFallAge, 4 + 2 * DIV_HALF * pulses);
      chk(lastFallAge > 0, "R4 burst ran during BUSY low", lastFallAge, 1);
    end
  endtask

  initial begin
    #(20 * 150000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    chk(adcCsN == 1'b0, "R1 csN reset", adcCsN, 0);
    chk(adcRdConvN == 1'b1, "R1 rdConvN reset", adcRdConvN, 1);
    chk(adcDclk == 1'b0, "R1 dclk reset", adcDclk, 0);
    chk(wordValid == 1'b0, "R1 wordValid reset", wordValid, 0);
    chk(frameErr == 1'b0, "R1 frameErr reset", frameErr, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(wordOut == 16'h0000, "R1 wordOut reset", wordOut, 0);
    chk(adcRdConvN == 1'b1, "R1 idle without request", adcRdConvN, 1);

    txn(1'b1, 1'b0, 16'hB38D, 1'b0, 16'hB38D, 1'b0, 1'b0);
    txn(1'b1, 1'b1, 16'h8001, 1'b0, 16'h8001, 1'b0, 1'b0);
    txn(1'b0, 1'b0, 16'h5A5A, 1'b0, 16'h8001, 1'b0, 1'b0);
    txn(1'b0, 1'b1, 16'hFFFF, 1'b0, 16'h5A5A, 1'b0, 1'b0);
    txn(1'b0, 1'b0, 16'h0000, 1'b0, 16'hFFFF, 1'b0, 1'b1);
    txn(1'b1, 1'b1, 16'h0F0F, 1'b1, 16'hFFFF, 1'b1, 1'b0);
    txn(1'b1, 1'b0, 16'h7777, 1'b1, 16'hFFFF, 1'b1, 1'b0);
    txn(1'b1, 1'b1, 16'h1234, 1'b0, 16'h1234, 1'b0, 1'b1);

    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

endmodule